// File: doc/BRIEF.md
# Two-Bank Legacy Interrupt Controller

This block gathers up to 32 device interrupt lines into two banks of 32-bit registers and presents one interrupt request to the processor. Each bank holds a pending-event register, an enable mask and a live line-level register. A line that changes state marks its bank bit as pending, subject to the mask. Software reads the banks through a small word-addressed register port and retires pending events through a per-bank clear register.

Bit 31 of the bank-1 mask selects the operating mode. When it is 1 the controller runs in legacy mode, where source changes are processed. When it is 0 the controller is in native mode, which this block does not implement. A source change in native mode is dropped and flagged on an error output. Every data word crossing the register port is byte-lane reversed, so bus bits [7:0] hold internal bits [31:24].

Top module: `dual_bank_intc`

## Requirements
- R1: After a synchronous reset every register reads as zero, and `cpu_irq` and `mode_err` are low.
- R2: Bus data is the 32-bit byte reversal of the internal value, in both directions. The identity register (byte offset 0x34) holds 0xF0700008 internally, so it reads 0x080070F0 on the bus.
- R3: Registers are selected by byte-offset bits [7:2], carried on `bus_word_addr`. The offsets are: bank-2 events 0x10, mask 0x14, clear 0x18, levels 0x1C; bank-1 events 0x20, mask 0x24, clear 0x28, levels 0x2C; identity 0x34; feature 0x38. Reads of clear registers and unmapped offsets return zero. Writes to the events, levels, identity or unmapped offsets change nothing.
- R4: A write to the bank-1 mask loads all 32 bits. In the same write, internal bit 31 is copied into bit 31 of the bank-2 mask, and the other bank-2 mask bits are kept.
- R5: A write to the bank-2 mask ORs the internal value into the register, with bit 31 left out of the OR.
- R6: A write to a clear register zeroes that bank's events when raw bus bit 7 is 1. Otherwise the events are ANDed with the internal (byte-reversed) value.
- R7: In legacy mode, source i with i ≥ 22 maps to bank-2 bit i−21. Source i ≤ 20 maps to bank-1 bit i+11. Source 21 falls outside both banks and has no effect.
- R8: In legacy mode, on a clock where a bank sees a mapped line change, its events become (events OR changed bits) AND mask. This drops pending bits whose mask bit is now 0.
- R9: In legacy mode, each changed line's levels bit takes the line's new value, whatever the mask holds.
- R10: `cpu_irq` is registered: it is high in the cycle after either events register is nonzero.
- R11: In native mode, source changes leave events and levels unchanged, and `mode_err` is high for exactly the clock after each such change.
- R12: The feature register at 0x38 stores any written word and reads it back unchanged.
- R13: When a clear write and a source change fall in the same clock, the clear acts first and the new events are then merged and masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_word_addr | input | 6 | Register select, byte-offset bits [7:2] |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data, bus byte order |
| bus_rdata | output | 32 | Read data for `bus_word_addr`, combinational, bus byte order |
| src_lines | input | 32 | Device interrupt line levels |
| cpu_irq | output | 1 | Processor interrupt request |
| mode_err | output | 1 | Source change seen while in native mode |

## Verification
The assertions assume that `src_lines` and the write inputs are stable across each rising edge. They also assume the mask is not rewritten in the same clock as a line change in that bank, since the masking rule uses the updated mask. The bench changes inputs only on falling edges. It steps a behavioural model on every rising edge from the same inputs, so same-clock clear and change combinations stay inside the assumed order.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int REG_W    = 32;
    localparam int MODE_BIT = 31;
    localparam int WIPE_BIT = 7;
    localparam logic [REG_W-1:0] CHIP_ID = 32'hF070_0008;

    typedef enum logic [5:0] {
        SEL_EV2 = 6'h04,
        SEL_MK2 = 6'h05,
        SEL_CL2 = 6'h06,
        SEL_LV2 = 6'h07,
        SEL_EV1 = 6'h08,
        SEL_MK1 = 6'h09,
        SEL_CL1 = 6'h0A,
        SEL_LV1 = 6'h0B,
        SEL_ID  = 6'h0D,
        SEL_FC  = 6'h0E
    } reg_sel_e;

    typedef struct packed {
        logic             mask_wr;
        logic             clr_wr;
        logic             clr_all;
        logic [REG_W-1:0] data;
    } bank_cmd_t;

    function automatic logic [REG_W-1:0] lane_swap(input logic [REG_W-1:0] d);
        return {d[7:0], d[15:8], d[23:16], d[31:24]};
    endfunction

endpackage

// File: rtl/irqc_router.sv
module irqc_router
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int SPLIT   = 21,
    parameter int UP      = 11
) (
    input  logic [NUM_SRC-1:0] chg,
    input  logic [NUM_SRC-1:0] line,
    output logic [REG_W-1:0]   b1_chg,
    output logic [REG_W-1:0]   b1_line,
    output logic [REG_W-1:0]   b2_chg,
    output logic [REG_W-1:0]   b2_line,
    output logic [NUM_SRC-1:0] stray
);

    for (genvar j = 0; j < REG_W; j++) begin : g_b1
        if (j >= UP && (j - UP) <= SPLIT && (j - UP) < NUM_SRC) begin : g_on
            assign b1_chg[j]  = chg[j-UP];
            assign b1_line[j] = line[j-UP];
        end else begin : g_off
            assign b1_chg[j]  = 1'b0;
            assign b1_line[j] = 1'b0;
        end
    end

    for (genvar j = 0; j < REG_W; j++) begin : g_b2
        if (j >= 1 && (j + SPLIT) < NUM_SRC) begin : g_on
            assign b2_chg[j]  = chg[j+SPLIT];
            assign b2_line[j] = line[j+SPLIT];
        end else begin : g_off
            assign b2_chg[j]  = 1'b0;
            assign b2_line[j] = 1'b0;
        end
    end

    // sources that land in neither bank: report their rising changes
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_stray
        if (i <= SPLIT && (i + UP) >= REG_W) begin : g_lost
            assign stray[i] = chg[i] & line[i];
        end else begin : g_kept
            assign stray[i] = 1'b0;
        end
    end

endmodule

// File: rtl/irqc_bank.sv
module irqc_bank
    import irqc_pkg::*;
#(
    parameter bit PRIMARY = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             legacy,
    input  bank_cmd_t        cmd,
    input  logic             mirror_wr,
    input  logic             mirror_bit,
    input  logic [REG_W-1:0] chg,
    input  logic [REG_W-1:0] line,
    output logic [REG_W-1:0] events,
    output logic [REG_W-1:0] mask,
    output logic [REG_W-1:0] levels
);

    logic [REG_W-1:0] mask_base, mask_n, ev_w, ev_n, lv_n;
    logic             hit;

    if (PRIMARY) begin : g_load
        always_comb mask_base = cmd.mask_wr ? cmd.data : mask;
    end else begin : g_or
        always_comb begin
            mask_base = mask;
            if (cmd.mask_wr) begin
                mask_base = mask | cmd.data;
                mask_base[MODE_BIT] = mask[MODE_BIT];
            end
        end
    end

    always_comb begin
        mask_n = mask_base;
        if (mirror_wr) mask_n[MODE_BIT] = mirror_bit;
    end

    assign hit = legacy && (chg != '0);

    always_comb begin
        ev_w = events;
        if (cmd.clr_wr) ev_w = cmd.clr_all ? '0 : (events & cmd.data);
        ev_n = hit ? ((ev_w | chg) & mask_n) : ev_w;
        lv_n = legacy ? ((levels & ~chg) | (line & chg)) : levels;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            events <= '0;
            mask   <= '0;
            levels <= '0;
        end else begin
            events <= ev_n;
            mask   <= mask_n;
            levels <= lv_n;
        end
    end

    // R6: a wipe with no concurrent change leaves nothing pending
    a_r6_wipe_empties: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_wr && cmd.clr_all && !hit) |=> (events == '0));

    // R13: wipe plus change leaves only the newly changed bits
    a_r13_wipe_then_merge: assert property (@(posedge clk) disable iff (rst)
        (cmd.clr_wr && cmd.clr_all && hit) |=> ((events & ~$past(chg)) == '0));

    // R8: after a merge nothing pending lies outside the mask
    a_r8_merge_masked: assert property (@(posedge clk) disable iff (rst)
        hit |=> ((events & ~mask) == '0));

    // R9: changed lines show their new level
    a_r9_level_follows: assert property (@(posedge clk) disable iff (rst)
        legacy |=> (((levels ^ $past(line)) & $past(chg)) == '0));

    // R11: native mode freezes the levels
    a_r11_native_hold: assert property (@(posedge clk) disable iff (rst)
        !legacy |=> $stable(levels));

    if (!PRIMARY) begin : g_chk_or
        // R5: an OR write never clears low mask bits
        a_r5_or_keeps: assert property (@(posedge clk) disable iff (rst)
            (cmd.mask_wr && !mirror_wr) |=>
                (((mask & $past(mask)) == $past(mask)) && (mask[MODE_BIT] == $past(mask[MODE_BIT]))));
    end

endmodule

// File: rtl/dual_bank_intc.sv
module dual_bank_intc
    import irqc_pkg::*;
#(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [5:0]         bus_word_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_lines,
    output logic               cpu_irq,
    output logic               mode_err
);

    logic [NUM_SRC-1:0] src_prev, change, stray;
    logic [REG_W-1:0]   wr_int, fc_q, rd_int;
    logic [REG_W-1:0]   ev1, mk1, lv1, ev2, mk2, lv2;
    logic [REG_W-1:0]   c1, l1, c2, l2;
    bank_cmd_t          cmd1, cmd2;
    logic               legacy;

    assign change = src_lines ^ src_prev;
    assign wr_int = lane_swap(bus_wdata);
    assign legacy = mk1[MODE_BIT];

    always_comb begin
        cmd1 = '{mask_wr: 1'b0, clr_wr: 1'b0, clr_all: bus_wdata[WIPE_BIT], data: wr_int};
        cmd2 = cmd1;
        if (bus_we) begin
            case (bus_word_addr)
                SEL_MK1: cmd1.mask_wr = 1'b1;
                SEL_CL1: cmd1.clr_wr  = 1'b1;
                SEL_MK2: cmd2.mask_wr = 1'b1;
                SEL_CL2: cmd2.clr_wr  = 1'b1;
                default: ;
            endcase
        end
    end

    irqc_router #(.NUM_SRC(NUM_SRC)) u_route (
        .chg(change), .line(src_lines),
        .b1_chg(c1), .b1_line(l1), .b2_chg(c2), .b2_line(l2), .stray(stray)
    );

    irqc_bank #(.PRIMARY(1'b1)) u_bank1 (
        .clk(clk), .rst(rst), .legacy(legacy), .cmd(cmd1),
        .mirror_wr(1'b0), .mirror_bit(1'b0), .chg(c1), .line(l1),
        .events(ev1), .mask(mk1), .levels(lv1)
    );

    irqc_bank #(.PRIMARY(1'b0)) u_bank2 (
        .clk(clk), .rst(rst), .legacy(legacy), .cmd(cmd2),
        .mirror_wr(cmd1.mask_wr), .mirror_bit(wr_int[MODE_BIT]), .chg(c2), .line(l2),
        .events(ev2), .mask(mk2), .levels(lv2)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_prev <= '0;
            fc_q     <= '0;
            cpu_irq  <= 1'b0;
            mode_err <= 1'b0;
        end else begin
            src_prev <= src_lines;
            if (bus_we && bus_word_addr == SEL_FC) fc_q <= wr_int;
            cpu_irq  <= (ev1 != '0) || (ev2 != '0);
            mode_err <= !legacy && (change != '0);
        end
    end

    always_comb begin
        case (bus_word_addr)
            SEL_EV2: rd_int = ev2;
            SEL_MK2: rd_int = mk2;
            SEL_LV2: rd_int = lv2;
            SEL_EV1: rd_int = ev1;
            SEL_MK1: rd_int = mk1;
            SEL_LV1: rd_int = lv1;
            SEL_ID:  rd_int = CHIP_ID;
            SEL_FC:  rd_int = fc_q;
            default: rd_int = '0;
        endcase
    end
    assign bus_rdata = lane_swap(rd_int);

    // R10: request is the one-cycle-late OR of both event banks
    a_r10_irq_late: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (cpu_irq == ($past(ev1) != '0 || $past(ev2) != '0)));

    // R4: a bank-1 mask write carries raw bus bit 7 into the bank-2 mode bit
    a_r4_mirror: assert property (@(posedge clk) disable iff (rst)
        (bus_we && bus_word_addr == SEL_MK1) |=> (mk2[MODE_BIT] == $past(bus_wdata[7])));

    // R7: a change confined to unmapped sources alters no bank state
    a_r7_stray_inert: assert property (@(posedge clk) disable iff (rst)
        (legacy && !bus_we && stray != '0 && change == stray) |=>
            ($stable(ev1) && $stable(ev2) && $stable(lv1) && $stable(lv2)));

    // R11: error flag only after a native-mode change
    a_r11_err_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(mode_err) |-> !$past(legacy));

endmodule

// File: tb/dual_bank_intc_test.sv
`timescale 1ns/1ps
module dual_bank_intc_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] src = '0;
    logic        irq, err;

    int total = 0;
    int fails = 0;
    bit run = 0;

    always #10 clk = ~clk;

    dual_bank_intc uut (
        .clk(clk), .rst(rst), .bus_word_addr(addr), .bus_we(we),
        .bus_wdata(wdata), .bus_rdata(rdata), .src_lines(src),
        .cpu_irq(irq), .mode_err(err)
    );

    // ---------------- behavioural model ----------------
    logic [31:0] m_ev1, m_mk1, m_lv1, m_ev2, m_mk2, m_lv2, m_fc, m_prev;
    logic        m_irq, m_err;

    function automatic logic [31:0] rev(input logic [31:0] v);
        logic [31:0] r;
        for (int b = 0; b < 4; b++) r[8*(3-b) +: 8] = v[8*b +: 8];
        return r;
    endfunction

    function automatic logic [31:0] m_read(input logic [5:0] a);
        logic [31:0] v;
        case (int'(a) * 4)
            'h10: v = m_ev2;  'h14: v = m_mk2;  'h1C: v = m_lv2;
            'h20: v = m_ev1;  'h24: v = m_mk1;  'h2C: v = m_lv1;
            'h34: v = 32'hF070_0008;
            'h38: v = m_fc;
            default: v = 32'h0;
        endcase
        return rev(v);
    endfunction

    always @(posedge clk) begin
        logic [31:0] chg, iv;
        logic        leg, hit1, hit2;
        longint      bit_v;
        if (rst) begin
            {m_ev1, m_mk1, m_lv1, m_ev2, m_mk2, m_lv2, m_fc, m_prev} = '0;
            m_irq = 0; m_err = 0;
        end else begin
            chg = src ^ m_prev;
            leg = m_mk1[31];
            m_irq = (m_ev1 != 0) || (m_ev2 != 0);
            m_err = !leg && (chg != 0);
            iv = rev(wdata);
            if (we) begin
                case (int'(addr) * 4)
                    'h24: begin m_mk1 = iv; m_mk2[31] = iv[31]; end
                    'h14: m_mk2 = m_mk2 | (iv & 32'h7FFF_FFFF);
                    'h28: m_ev1 = wdata[7] ? 32'h0 : (m_ev1 & iv);
                    'h18: m_ev2 = wdata[7] ? 32'h0 : (m_ev2 & iv);
                    'h38: m_fc = iv;
                    default: ;
                endcase
            end
            hit1 = 0; hit2 = 0;
            if (leg) begin
                for (int i = 0; i < 32; i++) begin
                    if (chg[i]) begin
                        bit_v = longint'(1) << i;
                        if (bit_v > 64'h20_0000) begin
                            bit_v = bit_v >> 21;
                            m_ev2 = m_ev2 | bit_v[31:0];
                            m_lv2 = src[i] ? (m_lv2 | bit_v[31:0]) : (m_lv2 & ~bit_v[31:0]);
                            hit2 = 1;
                        end else begin
                            bit_v = bit_v << 11;
                            if (bit_v[31:0] != 0) begin
                                m_ev1 = m_ev1 | bit_v[31:0];
                                m_lv1 = src[i] ? (m_lv1 | bit_v[31:0]) : (m_lv1 & ~bit_v[31:0]);
                                hit1 = 1;
                            end
                        end
                    end
                end
                if (hit1) m_ev1 = m_ev1 & m_mk1;
                if (hit2) m_ev2 = m_ev2 & m_mk2;
            end
            m_prev = src;
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R10 / R11: outputs compared against the model every clock
    always @(negedge clk) begin
        if (run && !rst) begin
            chk("R10 cpu_irq", {31'b0, irq}, {31'b0, m_irq});
            chk("R11 mode_err", {31'b0, err}, {31'b0, m_err});
        end
    end

    task automatic rd(input int ofs, input string tag);
        @(negedge clk);
        addr = 6'(ofs >> 2);
        #1;
        chk(tag, rdata, m_read(6'(ofs >> 2)));
    endtask

    task automatic wr_raw(input int ofs, input logic [31:0] d);
        @(negedge clk);
        addr = 6'(ofs >> 2); wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic wr(input int ofs, input logic [31:0] internal);
        wr_raw(ofs, rev(internal));
    endtask

    task automatic drive(input logic [31:0] v);
        @(negedge clk);
        src = v;
        repeat (2) @(negedge clk);
    endtask

    task automatic rd_all(input string tag);
        rd('h10, tag); rd('h14, tag); rd('h1C, tag);
        rd('h20, tag); rd('h24, tag); rd('h2C, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        run = 1;
        // R1: reset state
        rd_all("R1 reset");
        @(negedge clk); addr = 6'h08; #1; chk("R1 events1 zero", rdata, 32'h0);
        // R2: identity literal
        @(negedge clk); addr = 6'h0D; #1; chk("R2 id", rdata, 32'h0800_70F0);
        // R3: clear and unmapped reads, ignored writes
        rd('h18, "R3 clear read"); rd('h3C, "R3 unmapped read"); rd('h00, "R3 unmapped read");
        wr('h20, 32'hFFFF_FFFF); wr('h2C, 32'h1234_5678); wr('h34, 32'h0); wr('h3C, 32'hAAAA_5555);
        rd_all("R3 ignored writes"); rd('h34, "R3 id kept"); rd('h3C, "R3 unmapped kept");
        // R12: feature register round trip
        wr_raw('h38, 32'hDEAD_BEEF);
        @(negedge clk); addr = 6'h0E; #1; chk("R12 feature", rdata, 32'hDEAD_BEEF);
        // R5: OR write, bit 31 excluded
        wr('h14, 32'h8000_0006);
        @(negedge clk); addr = 6'h05; #1; chk("R5 or excl31", rdata, rev(32'h0000_0006));
        wr('h14, 32'h0000_0401);
        @(negedge clk); addr = 6'h05; #1; chk("R5 or accum", rdata, rev(32'h0000_0407));
        // R11: native mode changes ignored
        drive(32'h0000_0001);
        drive(32'h8000_0000);
        rd_all("R11 native");
        // R4: load bank-1 mask and mirror mode bit
        wr('h24, 32'hFFFF_F800);
        @(negedge clk); addr = 6'h05; #1; chk("R4 mirror set", rdata, rev(32'h8000_0407));
        rd('h24, "R4 load");
        wr('h14, 32'h7FFF_FFFF);
        // R7 / R8 / R9: routing of every source, rising then falling
        for (int i = 0; i < 32; i++) begin
            drive(src ^ (32'h1 << i));
            rd_all("R7 route");
        end
        for (int i = 0; i < 32; i++) begin
            drive(src ^ (32'h1 << i));
            rd_all("R9 levels");
        end
        // R7: source 21 alone leaves banks alone
        wr_raw('h28, 32'h0000_0080); wr_raw('h18, 32'h0000_0080);
        drive(src ^ 32'h0020_0000);
        @(negedge clk); addr = 6'h08; #1; chk("R7 src21 ev1", rdata, 32'h0);
        @(negedge clk); addr = 6'h04; #1; chk("R7 src21 ev2", rdata, 32'h0);
        // R6: AND clear (raw bit 7 clear) then wipe
        drive(src ^ 32'h0600_0003);
        rd_all("R6 before");
        wr('h18, 32'h7FFF_FFEF);
        rd('h10, "R6 and clear");
        wr('h28, 32'h7FFF_EFFF);
        rd('h20, "R6 and clear");
        wr_raw('h28, 32'h0000_0080);
        @(negedge clk); addr = 6'h08; #1; chk("R6 wipe", rdata, 32'h0);
        // R8: narrowing the mask drops pending bits at the next merge
        drive(src ^ 32'h0000_0003);
        wr('h24, 32'h8000_1000);
        rd('h20, "R8 pending kept");
        drive(src ^ 32'h0000_0004);
        rd_all("R8 masked merge");
        // R13: clear and change in the same clock
        wr('h24, 32'hFFFF_F800);
        drive(src ^ 32'h0000_0010);
        @(negedge clk);
        addr = 6'h0A; wdata = 32'h0000_0080; we = 1'b1; src = src ^ 32'h0000_0020;
        @(negedge clk);
        we = 1'b0;
        rd_all("R13 same clock");
        @(negedge clk);
        addr = 6'h0A; wdata = rev(32'h7FFF_FFFF); we = 1'b1; src = src ^ 32'h0000_0040;
        @(negedge clk);
        we = 1'b0;
        rd_all("R13 and plus merge");
        // R4: clearing the mode bit mirrors to bank 2, back to native
        wr('h24, 32'h0000_F800);
        rd('h14, "R4 mirror clear");
        drive(src ^ 32'h0000_0100);
        rd_all("R11 native again");
        // R1: reset mid-run
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        rd_all("R1 re-reset");
        repeat (3) @(negedge clk);
        run = 0;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule